// File: doc/BRIEF.md
# One-Wire ROM Identity Fetch Sequencer

This block sits above a one-wire bit/byte engine and reads the 64-bit ROM identity of the single device on the bus in response to one start pulse. It drives the engine through a small command handshake and runs a fixed sequence. First comes a bus reset with presence sampling. Then the read-ROM command byte is sent. Then eight bytes are read back. The first of these is the family code, the next six are the serial number, and the last is the CRC.

The results appear on dedicated outputs. The serial number is a 48-bit word in which the first serial byte read sits in the top eight bits, so the word reads as twelve hex digits in arrival order. The family byte and the CRC byte each have their own output. A no-device flag and an identity-valid flag report the presence result. The sequencer does not check the CRC. When no device answers, it still runs every byte slot so that a fetch always takes the same number of engine operations, and it flags the result as invalid.

Engine handshake: the sequencer raises `engCmdValid` for one cycle with `engOp` and `engTxByte` while `engBusy` is low. The engine reports completion with a one-cycle `engDone`, together with `engRxByte` after a read and `engPresence` after a reset.

Top module: `ow_rom_reader`

## Requirements
- R1: A `startReq` seen while `busy` is low begins a fetch, and `busy` is high on the next cycle.
- R2: The first engine command of a fetch is a bus reset (`engOp` = 1).
- R3: The second command is a byte write (`engOp` = 2) with `engTxByte` = 0x33.
- R4: After the write come exactly eight byte reads (`engOp` = 3), for exactly ten commands per fetch.
- R5: `familyCode` holds the first byte read, and that byte does not appear in `serialId`.
- R6: `serialId` holds read bytes two to seven, with read byte two in bits 47:40 and read byte seven in bits 7:0.
- R7: `crcByte` holds the eighth byte read.
- R8: If the reset reports no presence, `noDevice` is 1, `idValid` is 0, and all ten commands are still issued.
- R9: If presence is reported, `noDevice` is 0 and `idValid` is 1 when `done` rises.
- R10: `done` is high for exactly one cycle per fetch, after the last read completes, and `busy` is low in that cycle.
- R11: A `startReq` while `busy` is high is ignored: it adds no commands and no extra `done`.
- R12: `engCmdValid` is never raised while `engBusy` is high or while a command is outstanding.
- R13: After reset, `busy`, `done`, `idValid`, `noDevice`, `serialId`, `familyCode` and `crcByte` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Request one identity fetch |
| engBusy | input | 1 | Engine is executing a command |
| engDone | input | 1 | One-cycle pulse: command finished |
| engRxByte | input | 8 | Byte returned by a read command |
| engPresence | input | 1 | Presence result of a reset command |
| engCmdValid | output | 1 | One-cycle command strobe to the engine |
| engOp | output | 2 | Command: 1 reset, 2 write byte, 3 read byte |
| engTxByte | output | 8 | Byte for a write command |
| busy | output | 1 | Fetch in progress |
| done | output | 1 | One-cycle fetch-complete pulse |
| noDevice | output | 1 | No presence reported at reset |
| idValid | output | 1 | Identity captured from a present device |
| familyCode | output | 8 | First byte read |
| serialId | output | 48 | Six serial bytes, first-read byte most significant |
| crcByte | output | 8 | Eighth byte read |

## Verification
The assertions check the command order on every cycle: a reset first, then the write of 0x33, then reads only, with exactly ten commands before `done`. They also check that no command is issued to a busy engine, that `done` is a single-cycle pulse outside `busy`, and that the valid and no-device flags are never both set. Only the bench scenarios can show that each returned byte lands in the right field in the right position, across many byte patterns, engine latencies and presence results, and that a start repeated during a fetch leaves the command count and the `done` count unchanged.

// File: rtl/ow_rom_pkg.sv
package ow_rom_pkg;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_RESET = 2'd1,
    OP_WRITE = 2'd2,
    OP_READ  = 2'd3
  } engOp_t;

  // Strobes from control to datapath, valid for one cycle each.
  typedef struct packed {
    logic clearAll;
    logic capPresence;
    logic capFamily;
    logic shiftId;
    logic capCrc;
    logic finish;
  } ctlStrobes_t;

endpackage

// File: rtl/ow_rom_ctrl.sv
module ow_rom_ctrl
  import ow_rom_pkg::*;
#(
  parameter int          ID_BYTES = 6,
  parameter logic [7:0]  READ_CMD = 8'h33
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        startReq,
  input  logic        engBusy,
  input  logic        engDone,
  output logic        engCmdValid,
  output logic [1:0]  engOp,
  output logic [7:0]  engTxByte,
  output logic        busy,
  output ctlStrobes_t strobes
);

  // Step 0 reset, 1 command, 2 family, 3..ID_BYTES+2 serial, last CRC.
  localparam int LAST_STEP   = ID_BYTES + 3;
  localparam int FIRST_ID    = 3;
  localparam int LAST_ID     = ID_BYTES + 2;
  localparam int STEP_W      = $clog2(LAST_STEP + 1);
  localparam logic [STEP_W-1:0] LAST_STEP_V = STEP_W'(LAST_STEP);
  localparam logic [STEP_W-1:0] FIRST_ID_V  = STEP_W'(FIRST_ID);
  localparam logic [STEP_W-1:0] LAST_ID_V   = STEP_W'(LAST_ID);

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } ctlState_t;

  ctlState_t         state, stateNext;
  logic [STEP_W-1:0] step, stepNext;
  engOp_t            opForStep;

  always_comb begin
    if (step == '0)
      opForStep = OP_RESET;
    else if (step == STEP_W'(1))
      opForStep = OP_WRITE;
    else
      opForStep = OP_READ;
  end

  always_comb begin
    stateNext   = state;
    stepNext    = step;
    engCmdValid = 1'b0;
    strobes     = '0;
    case (state)
      ST_IDLE: begin
        if (startReq) begin
          strobes.clearAll = 1'b1;
          stepNext         = '0;
          stateNext        = ST_ISSUE;
        end
      end
      ST_ISSUE: begin
        if (!engBusy) begin
          engCmdValid = 1'b1;
          stateNext   = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (engDone) begin
          strobes.capPresence = (step == '0);
          strobes.capFamily   = (step == STEP_W'(2));
          strobes.shiftId     = (step >= FIRST_ID_V) && (step <= LAST_ID_V);
          strobes.capCrc      = (step == LAST_STEP_V);
          strobes.finish      = (step == LAST_STEP_V);
          if (step == LAST_STEP_V) begin
            stateNext = ST_IDLE;
          end else begin
            stepNext  = step + STEP_W'(1);
            stateNext = ST_ISSUE;
          end
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      step  <= '0;
    end else begin
      state <= stateNext;
      step  <= stepNext;
    end
  end

  assign engOp     = opForStep;
  assign engTxByte = (opForStep == OP_WRITE) ? READ_CMD : 8'h00;
  assign busy      = (state != ST_IDLE);

endmodule

// File: rtl/ow_rom_datapath.sv
module ow_rom_datapath
  import ow_rom_pkg::*;
#(
  parameter int ID_BYTES = 6
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctlStrobes_t           strobes,
  input  logic [7:0]            engRxByte,
  input  logic                  engPresence,
  output logic                  done,
  output logic                  noDevice,
  output logic                  idValid,
  output logic [7:0]            familyCode,
  output logic [ID_BYTES*8-1:0] serialId,
  output logic [7:0]            crcByte
);

  localparam int ID_W = ID_BYTES * 8;

  logic [ID_W-1:0] idShift;

  // Shift left by one byte: the earliest byte ends up in the top slot.
  generate
    if (ID_BYTES > 1) begin : g_multi
      always_comb idShift = {serialId[ID_W-9:0], engRxByte};
    end else begin : g_single
      always_comb idShift = engRxByte;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      done       <= 1'b0;
      noDevice   <= 1'b0;
      idValid    <= 1'b0;
      familyCode <= '0;
      serialId   <= '0;
      crcByte    <= '0;
    end else begin
      done <= strobes.finish;
      if (strobes.clearAll) begin
        noDevice   <= 1'b0;
        idValid    <= 1'b0;
        familyCode <= '0;
        serialId   <= '0;
        crcByte    <= '0;
      end
      if (strobes.capPresence) noDevice   <= !engPresence;
      if (strobes.capFamily)   familyCode <= engRxByte;
      if (strobes.shiftId)     serialId   <= idShift;
      if (strobes.capCrc)      crcByte    <= engRxByte;
      if (strobes.finish)      idValid    <= !noDevice;
    end
  end

endmodule

// File: rtl/ow_rom_reader.sv
module ow_rom_reader
  import ow_rom_pkg::*;
#(
  parameter int         ID_BYTES = 6,
  parameter logic [7:0] READ_CMD = 8'h33
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  startReq,
  input  logic                  engBusy,
  input  logic                  engDone,
  input  logic [7:0]            engRxByte,
  input  logic                  engPresence,
  output logic                  engCmdValid,
  output logic [1:0]            engOp,
  output logic [7:0]            engTxByte,
  output logic                  busy,
  output logic                  done,
  output logic                  noDevice,
  output logic                  idValid,
  output logic [7:0]            familyCode,
  output logic [ID_BYTES*8-1:0] serialId,
  output logic [7:0]            crcByte
);

  ctlStrobes_t strobes;

  ow_rom_ctrl #(.ID_BYTES(ID_BYTES), .READ_CMD(READ_CMD)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .startReq    (startReq),
    .engBusy     (engBusy),
    .engDone     (engDone),
    .engCmdValid (engCmdValid),
    .engOp       (engOp),
    .engTxByte   (engTxByte),
    .busy        (busy),
    .strobes     (strobes)
  );

  ow_rom_datapath #(.ID_BYTES(ID_BYTES)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .engRxByte   (engRxByte),
    .engPresence (engPresence),
    .done        (done),
    .noDevice    (noDevice),
    .idValid     (idValid),
    .familyCode  (familyCode),
    .serialId    (serialId),
    .crcByte     (crcByte)
  );

endmodule

// File: rtl/ow_rom_reader_chk.sv
module ow_rom_reader_chk #(
  parameter int         ID_BYTES = 6,
  parameter logic [7:0] READ_CMD = 8'h33
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  startReq,
  input logic                  engBusy,
  input logic                  engDone,
  input logic                  engCmdValid,
  input logic [1:0]            engOp,
  input logic [7:0]            engTxByte,
  input logic                  busy,
  input logic                  done,
  input logic                  noDevice,
  input logic                  idValid,
  input logic [ID_BYTES*8-1:0] serialId
);

  localparam int TOTAL_CMDS = ID_BYTES + 4;

  logic [7:0] cmdCount;
  logic       pending;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdCount <= '0;
      pending  <= 1'b0;
    end else begin
      if (!busy && startReq) cmdCount <= '0;
      else if (engCmdValid)  cmdCount <= cmdCount + 8'd1;
      if (engCmdValid)  pending <= 1'b1;
      else if (engDone) pending <= 1'b0;
    end
  end

  AST_START_TAKES: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && startReq) |=> busy); // R1
  AST_FIRST_RESET: assert property (@(posedge clk) disable iff (!rstN)
    (engCmdValid && cmdCount == 8'd0) |-> engOp == 2'd1); // R2
  AST_SECOND_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (engCmdValid && cmdCount == 8'd1) |-> (engOp == 2'd2 && engTxByte == READ_CMD)); // R3
  AST_THEN_READS: assert property (@(posedge clk) disable iff (!rstN)
    (engCmdValid && cmdCount >= 8'd2) |-> engOp == 2'd3); // R4
  AST_CMD_TOTAL: assert property (@(posedge clk) disable iff (!rstN)
    done |-> cmdCount == 8'(TOTAL_CMDS)); // R4
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(idValid && noDevice)); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R10
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy); // R10
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !startReq) |=> $stable(serialId)); // R11
  AST_NO_CMD_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    engCmdValid |-> (!engBusy && !pending)); // R12

endmodule

bind ow_rom_reader ow_rom_reader_chk #(.ID_BYTES(ID_BYTES), .READ_CMD(READ_CMD)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .startReq    (startReq),
  .engBusy     (engBusy),
  .engDone     (engDone),
  .engCmdValid (engCmdValid),
  .engOp       (engOp),
  .engTxByte   (engTxByte),
  .busy        (busy),
  .done        (done),
  .noDevice    (noDevice),
  .idValid     (idValid),
  .serialId    (serialId)
);

// File: tb/ow_rom_reader_tb.sv
module ow_rom_reader_tb;

  localparam int NB = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0;
  logic engBusy, engDone, engPresence;
  logic [7:0] engRxByte;
  logic engCmdValid, busy, done, noDevice, idValid;
  logic [1:0] engOp;
  logic [7:0] engTxByte, familyCode, crcByte;
  logic [NB*8-1:0] serialId;

  always #2.5 clk = ~clk;

  ow_rom_reader #(.ID_BYTES(NB)) u_dut (
    .clk(clk), .rstN(rstN), .startReq(startReq),
    .engBusy(engBusy), .engDone(engDone), .engRxByte(engRxByte),
    .engPresence(engPresence), .engCmdValid(engCmdValid), .engOp(engOp),
    .engTxByte(engTxByte), .busy(busy), .done(done), .noDevice(noDevice),
    .idValid(idValid), .familyCode(familyCode), .serialId(serialId),
    .crcByte(crcByte)
  );

  // Engine model
  logic [7:0] rom [0:7];
  int         lat = 0;
  logic       presSet = 1'b1;
  int         cnt, rdIdx, nOps, nDone;
  logic [1:0] curOp;
  logic [1:0] opLog [0:1023];
  logic [7:0] txLog [0:1023];

  always @(posedge clk) begin
    if (!rstN) begin
      engBusy <= 1'b0; engDone <= 1'b0; engRxByte <= 8'h00;
      engPresence <= 1'b0; cnt <= 0; rdIdx <= 0; nOps <= 0; nDone <= 0;
      curOp <= 2'd0;
    end else begin
      engDone <= 1'b0;
      if (done) nDone <= nDone + 1;
      if (engCmdValid) begin
        engBusy <= 1'b1;
        cnt     <= lat;
        curOp   <= engOp;
        if (nOps < 1024) begin
          opLog[nOps] <= engOp;
          txLog[nOps] <= engTxByte;
        end
        nOps <= nOps + 1;
        if (engOp == 2'd1) rdIdx <= 0;
      end else if (engBusy) begin
        if (cnt == 0) begin
          engBusy <= 1'b0;
          engDone <= 1'b1;
          if (curOp == 2'd1) engPresence <= presSet;
          if (curOp == 2'd3) begin
            engRxByte <= rom[rdIdx[2:0]];
            rdIdx     <= rdIdx + 1;
          end
        end else begin
          cnt <= cnt - 1;
        end
      end
    end
  end

  int nChecks = 0;
  int nFails  = 0;
  logic timedOut = 1'b0;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic runFetch(input int seed, input int latency, input logic pres, input logic pokeBusy);
    int baseOps, baseDone, waitCyc;
    logic [47:0] expId;
    logic seqOk, txOk;
    lat = latency;
    presSet = pres;
    for (int i = 0; i < 8; i++) rom[i] = 8'((seed * 37 + i * 59 + (seed >> 2) * 101 + 3) & 255);
    baseOps  = nOps;
    baseDone = nDone;
    @(negedge clk);
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    check("R1 busy after start", 64'(busy), 64'd1);
    waitCyc = 0;
    while (!done && waitCyc < 2000) begin
      if (pokeBusy) startReq = ((waitCyc % 3) == 0);
      @(negedge clk);
      waitCyc++;
    end
    startReq = 1'b0;
    check("R10 done reached", 64'(done), 64'd1);
    check("R10 busy low at done", 64'(busy), 64'd0);
    expId = '0;
    for (int i = 1; i <= 6; i++) expId = {expId[39:0], rom[i]};
    check("R5 family", 64'(familyCode), 64'(rom[0]));
    check("R6 serial", 64'(serialId), 64'(expId));
    check("R7 crc", 64'(crcByte), 64'(rom[7]));
    check("R8 noDevice", 64'(noDevice), 64'(!pres));
    check(pres ? "R9 idValid" : "R8 idValid low", 64'(idValid), 64'(pres));
    check(pokeBusy ? "R11 command count" : "R4 command count", 64'(nOps - baseOps), 64'd10);
    seqOk = 1'b1; txOk = 1'b1;
    for (int k = 0; k < 10; k++) begin
      if (opLog[baseOps + k] !== ((k == 0) ? 2'd1 : (k == 1) ? 2'd2 : 2'd3)) seqOk = 1'b0;
      if (k == 1 && txLog[baseOps + k] !== 8'h33) txOk = 1'b0;
    end
    check("R2 R4 command order", 64'(seqOk), 64'd1);
    check("R3 write byte 0x33", 64'(txOk), 64'd1);
    @(negedge clk);
    check("R10 done single cycle", 64'(done), 64'd0);
    check(pokeBusy ? "R11 single done" : "R10 single done", 64'(nDone - baseDone), 64'd1);
    check("R10 idle after done", 64'(busy), 64'd0);
    // Idle cycles with the results held
    repeat (3) @(negedge clk);
    check("R11 results held idle", 64'(serialId), 64'(expId));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    timedOut = 1'b1;
  end

  initial begin : main
    repeat (4) @(negedge clk);
    check("R13 busy reset", 64'(busy), 64'd0);
    check("R13 done reset", 64'(done), 64'd0);
    check("R13 flags reset", 64'({idValid, noDevice}), 64'd0);
    check("R13 fields reset", 64'({familyCode, crcByte}), 64'd0);
    check("R13 serial reset", 64'(serialId), 64'd0);
    check("R12 no command at reset", 64'(engCmdValid), 64'd0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check("R12 no command before start", 64'(nOps), 64'd0);
    for (int s = 0; s < 6; s++)
      for (int l = 0; l < 4; l++)
        for (int p = 0; p < 2; p++)
          if (!timedOut) runFetch(s * 8 + l * 2 + p, (l == 3) ? 6 : l, p[0], 1'b0);
    for (int s = 0; s < 4; s++)
      if (!timedOut) runFetch(100 + s, s, s[0], 1'b1);
    if (timedOut) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin : hardstop
    repeat (190000) @(posedge clk);
    $display("FAIL watchdog: actual hang expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks + 1, nFails + 1);
    $finish;
  end

endmodule